// File: doc/BRIEF.md
# Wavetable Voice Envelope Generator

This block shapes the loudness of one voice in a sample-playback synthesizer. It holds an attenuation value from 0 to 256 units, with one unit worth 0.375 dB and 256 units meaning silence. A key-on strobe starts an attack from silence toward full level. The envelope then falls through a first decay to a programmable level and a second decay toward silence. A key-off strobe moves it into release. When the second decay or the release reaches silence, the voice switches itself off.

Each stage takes a 4-bit rate field. The field becomes a 6-bit effective rate, scaled by the voice's octave, the top bit of its F-number and a rate-correction field. A per-rate step is added to a fixed-point attenuation on every sample tick. A damping bit and a pseudo-reverb bit can override the decay and release rate. The block is meant to be instantiated once per voice, or time-shared across voices by an outer sequencer.

Top module: `wtenv_gen`

## Requirements
- R1: After reset `atten` is 256 and `active` is 0, and they stay there until a key-on.
- R2: The effective rate of a field is 0 for field 0 and 63 for field 15. When `rate_corr` is 15 it is field×4. Otherwise it is (octave as 4-bit two's complement + `rate_corr`)×2 + `fnum_msb` + field×4, clamped to 0..63.
- R3: Attenuation is kept with 23 fraction bits, so 256 units is 2^31. The decay and release step of rate r is 2^31 / D(r), where D(r) is 240 for r ≥ 60 and (15 << (21 − r/4)) / (4 + r%4) otherwise. The attack step is 2^31 / A(r), where A(r) is 17 for r ≥ 60 and (67 << (15 − r/4)) / (4 + r%4) otherwise. Any rate below 4 gives a step of 0, which holds the envelope still.
- R4: A key-on while the key is released sets attenuation to 256 and `active` to 1, and starts the attack. On each tick the attack subtracts its step. When the step would reach or pass 0, attenuation becomes 0 and the envelope moves on to the first decay.
- R5: An effective attack rate of 63 sets attenuation to 0 at once, both on key-on and on a tick during the attack, and moves on to the first decay.
- R6: The first decay adds its step on each tick and moves to the second decay once attenuation reaches or passes `dec1_level`×8 units. A `dec1_level` of 0 skips the first decay.
- R7: The second decay and the release add their step on each tick. When the sum reaches or passes 256, attenuation is set to exactly 256 and `active` drops.
- R8: A key-on while the key is already held does not restart the envelope. A tick in that same cycle is still processed.
- R9: A key-off while the voice is active enters release from the current attenuation. A key-off while the voice is inactive changes nothing.
- R10: While `damp` is 1, the first decay, second decay and release run at effective rate 56.
- R11: While `reverb` is 1 and `damp` is 0, a decay or release tick with attenuation above 48 units uses rate 5 and sets an internal latch. The latch keeps rate 5 in force while `reverb` stays set. A fresh key-on clears the latch.
- R12: In a cycle with no tick and no strobe, attenuation and `active` do not change. Each change appears on the outputs one clock after the edge that sampled its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One envelope update per sample period |
| key_on | input | 1 | Key-on strobe |
| key_off | input | 1 | Key-off strobe |
| atk_rate | input | 4 | Attack rate field |
| dec1_rate | input | 4 | First decay rate field |
| dec1_level | input | 4 | First decay target, in units of 8 |
| dec2_rate | input | 4 | Second decay rate field |
| rel_rate | input | 4 | Release rate field |
| rate_corr | input | 4 | Rate correction; 15 turns key scaling off |
| octave | input | 4 | Voice octave, two's complement |
| fnum_msb | input | 1 | Top bit of the voice F-number |
| damp | input | 1 | Force fast decay and release |
| reverb | input | 1 | Pseudo-reverb enable |
| atten | output | 9 | Current attenuation, integer units 0..256 |
| active | output | 1 | Voice is sounding |

## Verification
Every stimulus, whether strobe, tick or field change, is sampled at one rising edge, and its effect is due on `atten` and `active` right after that edge. No further register lies on the path. The driver applies inputs at the falling edge and queues the value due after the next rising edge. The monitor compares it two time units after that rising edge, so each check falls in the single cycle its result belongs to. Long runs through the attack, the decays and the release check the output on every cycle, including the cycle in which the final step clamps to 256 and `active` falls.

// File: rtl/wtenv_pkg.sv
package wtenv_pkg;

   localparam int RATE_W    = 6;
   localparam int RATE_N    = 1 << RATE_W;
   localparam int FIELD_W   = 4;
   localparam int ATT_INT_W = 9;

   typedef enum logic [2:0] {
      ST_ATK      = 3'd0,
      ST_DEC1     = 3'd1,
      ST_DEC2     = 3'd2,
      ST_REL      = 3'd3,
      ST_DEC2_END = 3'd4,
      ST_REL_END  = 3'd5
   } wtenv_stage_e;

   // Divisor for the falling (decay/release) direction.
   function automatic longint fall_divisor(input int r);
      if (r < 4)   return 64'd0;
      if (r >= 60) return 64'd240;
      return (longint'(15) << (21 - r / 4)) / longint'(4 + r % 4);
   endfunction

   // Divisor for the rising-level (attack) direction.
   function automatic longint rise_divisor(input int r);
      if (r < 4 || r == 63) return 64'd0;
      if (r >= 60)          return 64'd17;
      return (longint'(67) << (15 - r / 4)) / longint'(4 + r % 4);
   endfunction

   function automatic longint step_of(input longint span, input longint div);
      if (div == 0) return 64'd0;
      return span / div;
   endfunction

endpackage

// File: rtl/wtenv_rate_scale.sv
module wtenv_rate_scale
   import wtenv_pkg::*;
(
   input  logic [FIELD_W-1:0] field,
   input  logic [3:0]         octave,
   input  logic [3:0]         corr,
   input  logic               fsel,
   output logic [RATE_W-1:0]  rate
);

   logic signed [7:0] oct_s;
   logic signed [7:0] corr_s;
   logic signed [7:0] fld_s;
   logic signed [7:0] raw;

   always_comb begin
      oct_s  = {{4{octave[3]}}, octave};
      corr_s = {4'b0000, corr};
      fld_s  = {4'b0000, field};
      raw    = ((oct_s + corr_s) <<< 1) + (fld_s <<< 2) + $signed({7'b0, fsel});
      if (field == '0)
         rate = '0;
      else if (field == '1)
         rate = 6'd63;
      else if (corr == 4'hF)
         rate = {field, 2'b00};
      else if (raw < 8'sd0)
         rate = '0;
      else if (raw > 8'sd63)
         rate = 6'd63;
      else
         rate = raw[RATE_W-1:0];
   end

endmodule

// File: rtl/wtenv_inc_table.sv
module wtenv_inc_table
   import wtenv_pkg::*;
#(
   parameter int FRAC_W = 23,
   parameter bit RISING = 1'b0
) (
   input  logic [RATE_W-1:0]           rate,
   output logic [FRAC_W+ATT_INT_W-1:0] inc
);

   localparam int     ACC_W = FRAC_W + ATT_INT_W;
   localparam longint SPAN  = longint'(256) << FRAC_W;

   logic [ACC_W-1:0] tbl [RATE_N];

   for (genvar gi = 0; gi < RATE_N; gi++) begin : g_ent
      if (RISING) begin : g_rise
         localparam longint VAL = step_of(SPAN, rise_divisor(gi));
         assign tbl[gi] = ACC_W'(VAL);
      end else begin : g_fall
         localparam longint VAL = step_of(SPAN, fall_divisor(gi));
         assign tbl[gi] = ACC_W'(VAL);
      end
   end

   assign inc = tbl[rate];

endmodule

// File: rtl/wtenv_gen.sv
module wtenv_gen
   import wtenv_pkg::*;
#(
   parameter int FRAC_W     = 23,
   parameter int KNEE_UNITS = 48,
   parameter int DAMP_RATE  = 56,
   parameter int RVB_RATE   = 5,
   parameter int LVL_SHIFT  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 key_on,
   input  logic                 key_off,
   input  logic [FIELD_W-1:0]   atk_rate,
   input  logic [FIELD_W-1:0]   dec1_rate,
   input  logic [FIELD_W-1:0]   dec1_level,
   input  logic [FIELD_W-1:0]   dec2_rate,
   input  logic [FIELD_W-1:0]   rel_rate,
   input  logic [3:0]           rate_corr,
   input  logic [3:0]           octave,
   input  logic                 fnum_msb,
   input  logic                 damp,
   input  logic                 reverb,
   output logic [ATT_INT_W-1:0] atten,
   output logic                 active
);

   localparam int               ACC_W = FRAC_W + ATT_INT_W;
   localparam logic [ACC_W-1:0] FULL  = ACC_W'(longint'(256) << FRAC_W);
   localparam logic [ACC_W-1:0] KNEE  = ACC_W'(longint'(KNEE_UNITS) << FRAC_W);

   if (FRAC_W < 16 || FRAC_W > 23) begin : g_bad_frac
      $error("wtenv_gen: FRAC_W must lie in 16..23");
   end
   if (KNEE_UNITS < 1 || KNEE_UNITS > 255) begin : g_bad_knee
      $error("wtenv_gen: KNEE_UNITS must lie in 1..255");
   end
   if (DAMP_RATE < 0 || DAMP_RATE >= RATE_N || RVB_RATE < 0 || RVB_RATE >= RATE_N) begin : g_bad_rate
      $error("wtenv_gen: override rates must fit the rate range");
   end
   if (LVL_SHIFT + FIELD_W > ATT_INT_W - 1) begin : g_bad_lvl
      $error("wtenv_gen: decay level must stay below silence");
   end

   wtenv_stage_e     stage, stage_n;
   logic [ACC_W-1:0] att, att_n;
   logic             key_held, held_n;
   logic             rvb_latch, latch_n;

   logic [FIELD_W-1:0] dec_field;
   logic [RATE_W-1:0]  atk_eff;
   logic [RATE_W-1:0]  dec_scaled;
   logic [RATE_W-1:0]  dec_rate;
   logic [ACC_W-1:0]   atk_inc;
   logic [ACC_W-1:0]   dec_inc;
   logic [ACC_W-1:0]   inc_cur;
   logic [ACC_W-1:0]   lim1;
   logic [ACC_W:0]     sum;
   logic               decaying;
   logic               rvb_sel;
   wtenv_stage_e       after_atk;

   always_comb begin
      unique case (stage)
         ST_DEC1: dec_field = dec1_rate;
         ST_DEC2: dec_field = dec2_rate;
         default: dec_field = rel_rate;
      endcase
   end

   wtenv_rate_scale u_atk_scale (
      .field  (atk_rate),
      .octave (octave),
      .corr   (rate_corr),
      .fsel   (fnum_msb),
      .rate   (atk_eff)
   );

   wtenv_rate_scale u_dec_scale (
      .field  (dec_field),
      .octave (octave),
      .corr   (rate_corr),
      .fsel   (fnum_msb),
      .rate   (dec_scaled)
   );

   assign decaying = (stage == ST_DEC1) || (stage == ST_DEC2) || (stage == ST_REL);
   assign active   = decaying || (stage == ST_ATK);
   assign rvb_sel  = !damp && reverb && (rvb_latch || (att > KNEE));

   always_comb begin
      if (damp)
         dec_rate = RATE_W'(DAMP_RATE);
      else if (rvb_sel)
         dec_rate = RATE_W'(RVB_RATE);
      else
         dec_rate = dec_scaled;
   end

   wtenv_inc_table #(.FRAC_W(FRAC_W), .RISING(1'b1)) u_atk_tbl (
      .rate (atk_eff),
      .inc  (atk_inc)
   );

   wtenv_inc_table #(.FRAC_W(FRAC_W), .RISING(1'b0)) u_dec_tbl (
      .rate (dec_rate),
      .inc  (dec_inc)
   );

   assign inc_cur   = (stage == ST_ATK) ? atk_inc : dec_inc;
   assign lim1      = ACC_W'(dec1_level) << (LVL_SHIFT + FRAC_W);
   assign sum       = {1'b0, att} + {1'b0, inc_cur};
   assign after_atk = (dec1_level == '0) ? ST_DEC2 : ST_DEC1;

   always_comb begin
      stage_n = stage;
      att_n   = att;
      held_n  = key_held;
      latch_n = rvb_latch;
      if (key_on && !key_held) begin
         held_n  = 1'b1;
         latch_n = 1'b0;
         if (atk_eff == 6'd63) begin
            att_n   = '0;
            stage_n = after_atk;
         end else begin
            att_n   = FULL;
            stage_n = ST_ATK;
         end
      end else if (key_off) begin
         held_n = 1'b0;
         if (active) stage_n = ST_REL;
      end else if (tick) begin
         unique case (stage)
            ST_ATK: begin
               if (atk_eff == 6'd63) begin
                  att_n   = '0;
                  stage_n = after_atk;
               end else if (inc_cur != '0) begin
                  if (att <= inc_cur) begin
                     att_n   = '0;
                     stage_n = after_atk;
                  end else begin
                     att_n = att - inc_cur;
                  end
               end
            end
            ST_DEC1: begin
               if (rvb_sel) latch_n = 1'b1;
               if (dec1_level == '0) begin
                  stage_n = ST_DEC2;
               end else if (inc_cur != '0) begin
                  att_n = sum[ACC_W-1:0];
                  if (sum >= {1'b0, lim1}) stage_n = ST_DEC2;
               end
            end
            ST_DEC2, ST_REL: begin
               if (rvb_sel) latch_n = 1'b1;
               if (inc_cur != '0) begin
                  if (sum >= {1'b0, FULL}) begin
                     att_n   = FULL;
                     stage_n = (stage == ST_DEC2) ? ST_DEC2_END : ST_REL_END;
                  end else begin
                     att_n = sum[ACC_W-1:0];
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage     <= ST_REL_END;
         att       <= FULL;
         key_held  <= 1'b0;
         rvb_latch <= 1'b0;
      end else begin
         stage     <= stage_n;
         att       <= att_n;
         key_held  <= held_n;
         rvb_latch <= latch_n;
      end
   end

   assign atten = att[ACC_W-1:FRAC_W];

endmodule

// File: rtl/wtenv_chk.sv
module wtenv_chk
   import wtenv_pkg::*;
#(
   parameter int FRAC_W    = 23,
   parameter int DAMP_RATE = 56
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       tick,
   input logic                       key_on,
   input logic                       key_off,
   input logic                       damp,
   input logic                       active,
   input logic                       key_held,
   input logic [ATT_INT_W-1:0]       atten,
   input logic [2:0]                 stage,
   input logic [RATE_W-1:0]          dec_rate,
   input logic [FRAC_W+ATT_INT_W-1:0] inc_cur
);

   logic in_fall;
   assign in_fall = (stage == ST_DEC1) || (stage == ST_DEC2) || (stage == ST_REL);

   assert_atten_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      atten <= 9'd256);

   assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> atten == 9'd256);

   assert_keyon_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (key_on && !key_held) |=> active && (atten == 9'd256 || atten == 9'd0));

   assert_rehit_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (key_on && key_held && !key_off && !tick) |=> $stable(atten) && $stable(stage));

   assert_release_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (key_off && !key_on && active) |=> stage == ST_REL);

   assert_zero_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !key_on && !key_off && (stage == ST_DEC2 || stage == ST_REL) && inc_cur == '0)
      |=> $stable(atten));

   assert_fall_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !key_on && !key_off && in_fall) |=> atten >= $past(atten));

   assert_damp_rate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (damp && in_fall) |-> dec_rate == RATE_W'(DAMP_RATE));

   assert_idle_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !key_on && !key_off) |=> $stable(atten) && $stable(active));

endmodule

bind wtenv_gen wtenv_chk #(.FRAC_W(FRAC_W), .DAMP_RATE(DAMP_RATE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .key_on   (key_on),
   .key_off  (key_off),
   .damp     (damp),
   .active   (active),
   .key_held (key_held),
   .atten    (atten),
   .stage    (stage),
   .dec_rate (dec_rate),
   .inc_cur  (inc_cur)
);

// File: tb/sim_wtenv_gen.sv
module sim_wtenv_gen;

   localparam int     CLK_PERIOD = 10;
   localparam longint SPAN       = longint'(1) << 31;
   localparam longint KNEE_V     = longint'(48) << 23;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, key_on = 1'b0, key_off = 1'b0;
   logic [3:0] ar = '0, d1r = '0, dl = '0, d2r = '0, rr = '0, rc = 4'hF, oct = '0;
   logic fmsb = 1'b0, damp = 1'b0, reverb = 1'b0;

   logic [3:0] p_ar = '0, p_d1r = '0, p_dl = '0, p_d2r = '0, p_rr = '0, p_rc = 4'hF, p_oct = '0;
   logic p_fmsb = 1'b0, p_damp = 1'b0, p_reverb = 1'b0;

   logic [8:0] atten;
   logic       active;

   wtenv_gen u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .key_on(key_on), .key_off(key_off),
      .atk_rate(ar), .dec1_rate(d1r), .dec1_level(dl), .dec2_rate(d2r), .rel_rate(rr),
      .rate_corr(rc), .octave(oct), .fnum_msb(fmsb), .damp(damp), .reverb(reverb),
      .atten(atten), .active(active)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int    n_run = 0;
   int    n_fail = 0;
   int    q_att[$];
   bit    q_act[$];
   string q_tag[$];

   // Reference state: 0 attack, 1 first decay, 2 second decay, 3 release, 4/5 ends
   int     m_stage = 5;
   longint m_att = SPAN;
   bit     m_held = 1'b0;
   bit     m_latch = 1'b0;

   function automatic int f_scale(int field, int o, int c, int f9);
      int os, s;
      if (field == 0) return 0;
      if (field == 15) return 63;
      if (c == 15) return field * 4;
      os = (o >= 8) ? o - 16 : o;
      s = (os + c) * 2 + f9 + field * 4;
      if (s < 0) return 0;
      if (s > 63) return 63;
      return s;
   endfunction

   function automatic longint f_inc(int r, bit rising);
      longint d;
      if (rising) begin
         if (r < 4 || r == 63) return 0;
         d = (r >= 60) ? 17 : (longint'(67) << (15 - r / 4)) / (4 + r % 4);
      end else begin
         if (r < 4) return 0;
         d = (r >= 60) ? 240 : (longint'(15) << (21 - r / 4)) / (4 + r % 4);
      end
      return SPAN / d;
   endfunction

   function automatic int sc(logic [3:0] field);
      return f_scale(int'(field), int'(oct), int'(rc), int'(fmsb));
   endfunction

   task automatic model_cycle(bit kon, bit koff, bit tk);
      bit     act = (m_stage < 4);
      int     nxt_after = (dl == 0) ? 2 : 1;
      int     r;
      longint inc;
      bit     rv;
      logic [3:0] fld;
      if (kon && !m_held) begin
         m_held = 1; m_latch = 0;
         if (sc(ar) == 63) begin m_att = 0; m_stage = nxt_after; end
         else begin m_att = SPAN; m_stage = 0; end
      end else if (koff) begin
         m_held = 0;
         if (act) m_stage = 3;
      end else if (tk) begin
         if (m_stage == 0) begin
            r = sc(ar);
            if (r == 63) begin m_att = 0; m_stage = nxt_after; end
            else begin
               inc = f_inc(r, 1'b1);
               if (inc != 0) begin
                  if (m_att <= inc) begin m_att = 0; m_stage = nxt_after; end
                  else m_att = m_att - inc;
               end
            end
         end else if (m_stage >= 1 && m_stage <= 3) begin
            fld = (m_stage == 1) ? d1r : (m_stage == 2) ? d2r : rr;
            rv = !damp && reverb && (m_latch || m_att > KNEE_V);
            r = damp ? 56 : rv ? 5 : sc(fld);
            if (rv) m_latch = 1;
            inc = f_inc(r, 1'b0);
            if (m_stage == 1) begin
               if (dl == 0) m_stage = 2;
               else if (inc != 0) begin
                  m_att = m_att + inc;
                  if (m_att >= (longint'(dl) * 8) << 23) m_stage = 2;
               end
            end else if (inc != 0) begin
               if (m_att + inc >= SPAN) begin
                  m_att = SPAN;
                  m_stage = (m_stage == 2) ? 4 : 5;
               end else m_att = m_att + inc;
            end
         end
      end
   endtask

   task automatic check(bit ok, string tag, int got_att, int got_act, int exp_att, int exp_act);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: atten=%0d active=%0d, expected atten=%0d active=%0d",
                  tag, got_att, got_act, exp_att, exp_act);
      end
   endtask

   // Driver: applies one cycle of stimulus at the falling edge and queues the result due after the next rising edge.
   task automatic step(bit kon, bit koff, bit tk, string tag);
      @(negedge clk);
      ar = p_ar; d1r = p_d1r; dl = p_dl; d2r = p_d2r; rr = p_rr; rc = p_rc; oct = p_oct;
      fmsb = p_fmsb; damp = p_damp; reverb = p_reverb;
      key_on = kon; key_off = koff; tick = tk;
      model_cycle(kon, koff, tk);
      q_att.push_back(int'(m_att >> 23));
      q_act.push_back(m_stage < 4);
      q_tag.push_back(tag);
   endtask

   task automatic run(int n, string tag);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, tag);
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, tag);
   endtask

   // Monitor: compares two time units after each rising edge.
   always @(posedge clk) begin
      #2;
      if (q_att.size() > 0) begin
         int    ea;
         bit    ev;
         string et;
         ea = q_att.pop_front();
         ev = q_act.pop_front();
         et = q_tag.pop_front();
         check((int'(atten) == ea) && (active == ev), et, int'(atten), int'(active), ea, int'(ev));
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog (R1..all): run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(atten == 9'd256 && active == 1'b0, "R1 in reset", int'(atten), int'(active), 256, 0);
      rst_n = 1'b1;
      idle(3, "R1");
      run(3, "R1");

      // Instant attack, first decay to 16 units, second decay to silence
      p_ar = 4'd15; p_dl = 4'd2; p_d1r = 4'd15; p_d2r = 4'd15;
      step(1'b1, 1'b0, 1'b0, "R5");
      run(20, "R6");
      run(240, "R7");
      step(1'b0, 1'b1, 1'b0, "R9");
      run(3, "R9");

      // Timed attack, skipped first decay, re-hit, idle, release
      p_ar = 4'd14; p_dl = 4'd0; p_d2r = 4'd9;
      step(1'b1, 1'b0, 1'b0, "R4");
      run(40, "R4");
      run(10, "R6");
      step(1'b1, 1'b0, 1'b1, "R8");
      step(1'b1, 1'b0, 1'b0, "R8");
      run(5, "R8");
      idle(5, "R12");
      p_rr = 4'd15;
      step(1'b0, 1'b1, 1'b0, "R9");
      run(250, "R9");

      // Frozen attack, attack rate raised mid-way, frozen second decay
      p_ar = 4'd0;
      step(1'b1, 1'b0, 1'b0, "R3");
      run(20, "R3");
      p_ar = 4'd15; p_d2r = 4'd0;
      run(3, "R5");
      run(10, "R3");
      step(1'b0, 1'b1, 1'b0, "R9");
      run(250, "R9");

      // Damping overrides a slow second decay
      p_damp = 1'b1; p_d2r = 4'd1;
      step(1'b1, 1'b0, 1'b0, "R10");
      run(500, "R10");
      p_damp = 1'b0;
      step(1'b0, 1'b1, 1'b0, "R10");

      // Pseudo-reverb: slow-down past 48 units, latch kept into release, cleared by key-on
      p_reverb = 1'b1; p_dl = 4'd15; p_d1r = 4'd15;
      step(1'b1, 1'b0, 1'b0, "R11");
      run(260, "R11");
      step(1'b0, 1'b1, 1'b0, "R11");
      run(50, "R11");
      p_ar = 4'd14;
      step(1'b1, 1'b0, 1'b0, "R11");
      run(80, "R11");
      p_reverb = 1'b0;
      step(1'b0, 1'b1, 1'b0, "R11");
      run(250, "R9");

      // Key-scaled rates: clamp high, mid value, clamp low, negative octave
      p_rc = 4'd14; p_oct = 4'd7; p_fmsb = 1'b1; p_ar = 4'd10; p_dl = 4'd0; p_d2r = 4'd3;
      step(1'b1, 1'b0, 1'b0, "R2");
      run(100, "R2");
      p_oct = 4'd8; p_rc = 4'd0; p_fmsb = 1'b0;
      run(10, "R2");
      p_oct = 4'hE; p_rc = 4'd5; p_d2r = 4'd13; p_fmsb = 1'b1;
      run(50, "R2");
      p_rc = 4'hF;
      run(50, "R2");
      p_rr = 4'd15;
      step(1'b0, 1'b1, 1'b0, "R9");
      run(250, "R7");
      idle(4, "R12");

      @(posedge clk);
      #(CLK_PERIOD);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule